// File: doc/BRIEF.md
# Receiver Flow-Control Request Line

This block drives an active-low request-to-send line for a serial receiver. The line tells the remote transmitter whether it may keep sending. The block watches two things: the receive FIFO's fill state and the pulse the receiver raises when it accepts a valid start bit. A character that begins while every FIFO position is taken makes the block negate the line, which pauses the far end. As soon as a position frees up, the block asserts the line again.

Two enable bits come from the configuration logic, one for the receiver side and one for the transmitter side. Only the receiver enable arms this logic. When both bits are set, the two claims are treated as conflicting and the receiver control is cancelled. The output then stays asserted. The block holds a single bit of state, and its output is registered.

Top module: `rx_rts_ctl`

## Requirements
- R1: After reset, `rts_n` is 0 (asserted, remote may send).
- R2: With `rx_rts_en`=1 and `tx_rts_en`=0, a cycle with `start_seen`=1, `fifo_full`=1 and `slot_free`=0 drives `rts_n` to 1 on the following clock.
- R3: `fifo_full`=1 with no `start_seen` pulse never negates `rts_n`. It stays 0 on the next clock.
- R4: While `rts_n` is 1, a cycle with `slot_free`=1 returns `rts_n` to 0 on the next clock.
- R5: A `start_seen` pulse while `fifo_full`=0 leaves `rts_n` at 0.
- R6: With `rx_rts_en`=0, `rts_n` is 0 on the clock after every cycle, whatever the other inputs are.
- R7: With `rx_rts_en`=1 and `tx_rts_en`=1, the control is cancelled and `rts_n` is 0 on the next clock.
- R8: Clearing the enable while `rts_n` is 1 makes `rts_n` 0 on the very next clock.
- R9: `start_seen`=1 together with `slot_free`=1 (a pop in the same cycle) leaves `rts_n` at 0, even with `fifo_full`=1.
- R10: While enabled and negated with `slot_free`=0, `rts_n` stays 1, whether or not further start pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_rts_en | input | 1 | Receiver flow-control enable |
| tx_rts_en | input | 1 | Transmitter flow-control enable (conflicts when both set) |
| start_seen | input | 1 | One-cycle pulse: valid start bit detected |
| fifo_full | input | 1 | Receive FIFO has no empty position |
| slot_free | input | 1 | A FIFO position is available this cycle (not full, or being popped) |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Two events can land in the same cycle: a start pulse that would negate the line, and a FIFO pop that releases a slot. In that case the release must win. The bench provokes this directly, raising the start pulse, the full flag and the free-slot flag together, both from the asserted state and from the negated state. It also provokes it at random, through independently drawn inputs. A reference function decides the expected level one clock later, and the bench compares the output against that prediction.

// File: rtl/rx_rts_ctl.sv
module rx_rts_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_rts_en,
  input  logic tx_rts_en,
  input  logic start_seen,
  input  logic fifo_full,
  input  logic slot_free,
  output logic rts_n
);

  logic armed;
  logic blocked;
  logic hold_nxt;

  assign armed    = rx_rts_en & ~tx_rts_en;
  assign blocked  = start_seen & fifo_full;
  assign hold_nxt = armed & ~slot_free & (rts_n | blocked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n <= 1'b0;
    else        rts_n <= hold_nxt;
  end

endmodule

module rx_rts_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_rts_en,
  input logic tx_rts_en,
  input logic start_seen,
  input logic fifo_full,
  input logic slot_free,
  input logic rts_n
);

  p_negate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rts_en && !tx_rts_en && start_seen && fifo_full && !slot_free) |=> rts_n);

  p_full_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_n && !start_seen) |=> !rts_n);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_free |=> !rts_n);

  p_not_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_n && !fifo_full) |=> !rts_n);

  p_rx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rts_en |=> !rts_n);

  p_conflict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rts_en && tx_rts_en) |=> !rts_n);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_n && rx_rts_en && !tx_rts_en && !slot_free) |=> rts_n);

endmodule

bind rx_rts_ctl rx_rts_ctl_chk u_chk (.*);

// File: tb/rx_rts_ctl_tb.sv
`timescale 1ns/1ps
module rx_rts_ctl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_rts_en = 1'b0, tx_rts_en = 1'b0, start_seen = 1'b0, fifo_full = 1'b0, slot_free = 1'b0;
  logic rts_n;

  int checks = 0;
  int errors = 0;
  bit exp_n = 1'b0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_rts_ctl u_dut (.*);

  function automatic bit model_next(bit cur, bit rx, bit tx, bit st, bit fu, bit fr);
    bit en;
    en = rx & ~tx;
    if (!en) return 1'b0;
    if (fr) return 1'b0;
    return cur | (st & fu);
  endfunction

  function automatic string classify(bit cur, bit rx, bit tx, bit st, bit fu, bit fr);
    if (cur && !(rx && !tx)) return "R8";
    if (!rx) return "R6";
    if (tx) return "R7";
    if (st && fr) return "R9";
    if (cur && fr) return "R4";
    if (cur) return "R10";
    if (st && fu) return "R2";
    if (st) return "R5";
    if (fu) return "R3";
    return "R5";
  endfunction

  task automatic check(string t);
    checks++;
    if (rts_n !== exp_n) begin
      errors++;
      $display("FAIL %s rts_n=%0b expected=%0b at %0t", t, rts_n, exp_n, $time);
    end
  endtask

  task automatic step(bit rx, bit tx, bit st, bit fu, bit fr);
    rx_rts_en = rx; tx_rts_en = tx; start_seen = st; fifo_full = fu; slot_free = fr;
    tag   = classify(exp_n, rx, tx, st, fu, fr);
    exp_n = model_next(exp_n, rx, tx, st, fu, fr);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    step(1,0,0,1,0);  // R3 full alone
    step(1,0,1,0,1);  // R5 start, not full
    step(1,0,1,1,0);  // R2 negate
    step(1,0,1,1,0);  // R10 hold with more starts
    step(1,0,0,1,0);  // R10
    step(1,0,0,0,1);  // R4 release
    step(1,0,1,1,1);  // R9 start plus pop
    step(1,0,1,1,0);  // R2
    step(1,0,1,1,1);  // R9 from negated
    step(1,0,1,1,0);  // R2
    step(0,0,0,1,0);  // R8 enable cleared
    step(0,0,1,1,0);  // R6
    step(1,1,1,1,0);  // R7 both claimed
    step(1,0,1,1,0);  // R2
    step(1,1,0,1,0);  // R8 via conflict
    step(1,1,1,1,0);  // R7

    for (int i = 0; i < 4000; i++) begin
      bit rx, tx, st, fu, fr;
      rx = ($urandom % 8) != 0;
      tx = ($urandom % 6) == 0;
      st = ($urandom % 3) == 0;
      fu = ($urandom % 2) == 0;
      fr = ($urandom % 5) == 0;
      step(rx, tx, st, fu, fr);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule